// File: doc/BRIEF.md
# Write-Data Channel Fall-Through FIFO

This block buffers the write-data channel of a memory-mapped AXI link inside one clock domain. An upstream sender offers beats on a valid/ready input port. A downstream receiver takes them from a valid/ready output port. Inside, the data, byte strobes, last flag and user sideband of each beat are joined into one storage word. On the way out the word is split back into the same four fields, so the bus format is the same on both sides.

The output runs in fall-through mode. The oldest stored beat is always on the output fields, with valid high, and no separate read request is needed. Two occupancy counts and two inclusive threshold flags let surrounding logic throttle traffic before the buffer runs full or dry. The active-low reset acts asynchronously and clears the buffer to empty.

Top module: `wchan_fwft_fifo`

## Requirements
- R1: A beat is taken in only on a rising edge where `s_wvalid` and `s_wready` are both high. A beat is handed out only on an edge where `m_wvalid` and `m_wready` are both high. Offers made while `s_wready` is low leave the count and the stored contents unchanged.
- R2: `s_wready` is high whenever the buffer holds fewer than DEPTH beats. It is low when the buffer holds DEPTH beats.
- R3: `m_wvalid` is high whenever at least one beat is stored. It is low when the buffer is empty.
- R4: The data, strobe, last and user fields of a beat leave the output unchanged from how they entered.
- R5: In fall-through operation, a beat pushed into an empty buffer appears on the output fields with `m_wvalid` high in the cycle right after the accepting edge, without any read request.
- R6: Beats leave in the order they were accepted.
- R7: `wr_count` and `rd_count` both equal the number of stored beats, including the beat shown at the output. They are log2(DEPTH)+1 bits wide and read DEPTH when full. A push and a pop on the same edge leave the count unchanged.
- R8: `almost_empty` is high exactly when the count is less than or equal to AEMPTY_TH.
- R9: `almost_full` is high exactly when the count is greater than or equal to AFULL_TH.
- R10: While `rst_n` is low, the count is 0 and both `m_wvalid` and `s_wready` are low, starting from the moment reset is asserted and without waiting for a clock edge. `s_wready` stays low until the first rising edge after reset is released, and then rises.
- R11: When the buffer is full and a pop happens, `s_wready` stays low in that same cycle, so a push offered alongside the pop is not taken. In the next cycle `s_wready` is high and the count is DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_wdata | input | DATA_W | Incoming beat data |
| s_wstrb | input | DATA_W/8 | Incoming byte strobes |
| s_wlast | input | 1 | Incoming last-beat flag |
| s_wuser | input | USER_W | Incoming user sideband |
| s_wvalid | input | 1 | Sender offers a beat |
| s_wready | output | 1 | Buffer can accept a beat |
| m_wdata | output | DATA_W | Head beat data |
| m_wstrb | output | DATA_W/8 | Head beat strobes |
| m_wlast | output | 1 | Head beat last flag |
| m_wuser | output | USER_W | Head beat user sideband |
| m_wvalid | output | 1 | A beat is presented |
| m_wready | input | 1 | Receiver takes the presented beat |
| wr_count | output | log2(DEPTH)+1 | Stored beats, write-side view |
| rd_count | output | log2(DEPTH)+1 | Stored beats available to read |
| almost_full | output | 1 | Count at or above AFULL_TH |
| almost_empty | output | 1 | Count at or below AEMPTY_TH |

## Verification
A wrong occupancy count shows up on the count outputs in the very next cycle. Within a handful of cycles it also shows up as a threshold flag switching at the wrong level, or as `s_wready` or `m_wvalid` being wrong at the full or empty boundary. A read or write pointer that has slipped does not affect the counts. It appears as a wrong or reordered beat on the output fields, and only once the bad slot reaches the head, which can take up to DEPTH pops. For that reason the bench fills the buffer completely and drains every beat, checking the fields of each one. The one-cycle hold-off of ready after reset, and the rule that ready follows only the registered count when the buffer is full, are each checked in the exact cycle where they apply.

// File: rtl/wfifo_pkg.sv
package wfifo_pkg;

  // Occupancy after one edge, given the accepted push and pop.
  function automatic int unsigned occ_next(int unsigned occ, logic push, logic pop);
    int unsigned n;
    n = occ;
    if (push) n = n + 1;
    if (pop)  n = n - 1;
    return n;
  endfunction

  // Inclusive threshold comparisons used by the flags.
  function automatic logic at_or_above(int unsigned v, int unsigned th);
    return (v >= th);
  endfunction

  function automatic logic at_or_below(int unsigned v, int unsigned th);
    return (v <= th);
  endfunction

  function automatic logic is_pow2(int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/wfifo_pack.sv
module wfifo_pack #(
  parameter int DATA_W = 32,
  parameter int USER_W = 4,
  localparam int STRB_W = DATA_W / 8,
  localparam int WORD_W = DATA_W + STRB_W + 1 + USER_W
) (
  input  logic [DATA_W-1:0] in_data,
  input  logic [STRB_W-1:0] in_strb,
  input  logic              in_last,
  input  logic [USER_W-1:0] in_user,
  output logic [WORD_W-1:0] packed_word,
  input  logic [WORD_W-1:0] stored_word,
  output logic [DATA_W-1:0] out_data,
  output logic [STRB_W-1:0] out_strb,
  output logic              out_last,
  output logic [USER_W-1:0] out_user
);
  // Field layout, from the LSB up: data, strobes, last, user.
  localparam int STRB_LO = DATA_W;
  localparam int LAST_AT = DATA_W + STRB_W;
  localparam int USER_LO = LAST_AT + 1;

  always_comb begin
    packed_word = {in_user, in_last, in_strb, in_data};
  end

  always_comb begin
    out_data = stored_word[DATA_W-1:0];
    out_strb = stored_word[STRB_LO +: STRB_W];
    out_last = stored_word[LAST_AT];
    out_user = stored_word[USER_LO +: USER_W];
  end
endmodule

// File: rtl/wfifo_store.sv
module wfifo_store #(
  parameter int WORD_W = 41,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] head_word
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;

  // Pointers wrap on their own because DEPTH is a power of two.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_word;
  end

  // Fall-through: the head slot is always visible.
  assign head_word = mem[rd_ptr];

  AST_HEAD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop) |=> $stable(rd_ptr)) else $error("head moved without pop"); // R6
endmodule

// File: rtl/wfifo_level.sv
module wfifo_level #(
  parameter int DEPTH     = 16,
  parameter int AFULL_TH  = 12,
  parameter int AEMPTY_TH = 3,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] occ,
  output logic             room,
  output logic             avail,
  output logic             almost_full,
  output logic             almost_empty
);
  import wfifo_pkg::*;

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic armed;  // set on the first edge after reset is released

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ   <= '0;
      armed <= 1'b0;
    end else begin
      occ   <= CNT_W'(occ_next(int'(occ), push, pop));
      armed <= 1'b1;
    end
  end

  // Ready depends only on registered state, never on the same-cycle pop.
  assign room         = armed && (occ != FULL_CNT);
  assign avail        = (occ != '0);
  assign almost_full  = at_or_above(int'(occ), AFULL_TH);
  assign almost_empty = at_or_below(int'(occ), AEMPTY_TH);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL_CNT) else $error("count above depth"); // R7
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (occ < FULL_CNT)) else $error("push while full"); // R2
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (occ != '0)) else $error("pop while empty"); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (occ == CNT_W'($past(occ) + $past(push) - $past(pop))))
    else $error("count step wrong"); // R7
  AST_AFULL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(almost_full) |-> ($past(occ) == CNT_W'(AFULL_TH - 1)))
    else $error("almost_full rose at wrong level"); // R9
  AST_AEMPTY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(almost_empty) |-> (occ == CNT_W'(AEMPTY_TH + 1)))
    else $error("almost_empty fell at wrong level"); // R8
endmodule

// File: rtl/wchan_fwft_fifo.sv
module wchan_fwft_fifo #(
  parameter int DATA_W    = 32,
  parameter int USER_W    = 4,
  parameter int DEPTH     = 16,
  parameter int AFULL_TH  = 12,
  parameter int AEMPTY_TH = 3,
  localparam int STRB_W = DATA_W / 8,
  localparam int WORD_W = DATA_W + STRB_W + 1 + USER_W,
  localparam int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wlast,
  input  logic [USER_W-1:0] s_wuser,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [DATA_W-1:0] m_wdata,
  output logic [STRB_W-1:0] m_wstrb,
  output logic              m_wlast,
  output logic [USER_W-1:0] m_wuser,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [CNT_W-1:0]  wr_count,
  output logic [CNT_W-1:0]  rd_count,
  output logic              almost_full,
  output logic              almost_empty
);
  import wfifo_pkg::*;

  generate
    if (!is_pow2(DEPTH) || DEPTH < 16) begin : g_bad_depth
      initial $error("DEPTH must be a power of two and at least 16");
    end
  endgenerate

  // Named internal events for the checks below.
  logic              push_evt;
  logic              pop_evt;
  logic [WORD_W-1:0] in_word;
  logic [WORD_W-1:0] head_word;
  logic [CNT_W-1:0]  occ;

  assign push_evt = s_wvalid && s_wready;
  assign pop_evt  = m_wvalid && m_wready;

  wfifo_pack #(.DATA_W(DATA_W), .USER_W(USER_W)) u_pack (
    .in_data     (s_wdata),
    .in_strb     (s_wstrb),
    .in_last     (s_wlast),
    .in_user     (s_wuser),
    .packed_word (in_word),
    .stored_word (head_word),
    .out_data    (m_wdata),
    .out_strb    (m_wstrb),
    .out_last    (m_wlast),
    .out_user    (m_wuser)
  );

  wfifo_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_evt),
    .pop       (pop_evt),
    .wr_word   (in_word),
    .head_word (head_word)
  );

  wfifo_level #(.DEPTH(DEPTH), .AFULL_TH(AFULL_TH), .AEMPTY_TH(AEMPTY_TH)) u_level (
    .clk          (clk),
    .rst_n        (rst_n),
    .push         (push_evt),
    .pop          (pop_evt),
    .occ          (occ),
    .room         (s_wready),
    .avail        (m_wvalid),
    .almost_full  (almost_full),
    .almost_empty (almost_empty)
  );

  assign wr_count = occ;
  assign rd_count = occ;

  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wvalid && !m_wready) |=> (m_wvalid && $stable(head_word)))
    else $error("head changed while stalled"); // R4
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && !m_wvalid) |=> (m_wvalid && head_word == $past(in_word)))
    else $error("first beat did not fall through"); // R5
  AST_READY_WHILE_POP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && occ == CNT_W'(DEPTH)) |-> !s_wready)
    else $error("ready not from registered count"); // R11
endmodule

// File: tb/wchan_fwft_fifo_tb.sv
module wchan_fwft_fifo_tb;
  localparam int DATA_W = 32;
  localparam int USER_W = 4;
  localparam int DEPTH  = 16;
  localparam int AFT    = 12;
  localparam int AET    = 3;
  localparam int STRB_W = DATA_W / 8;
  localparam int WORD_W = DATA_W + STRB_W + 1 + USER_W;
  localparam int CNT_W  = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DATA_W-1:0] s_wdata = '0;
  logic [STRB_W-1:0] s_wstrb = '0;
  logic s_wlast = 1'b0;
  logic [USER_W-1:0] s_wuser = '0;
  logic s_wvalid = 1'b0;
  logic s_wready;
  logic [DATA_W-1:0] m_wdata;
  logic [STRB_W-1:0] m_wstrb;
  logic m_wlast;
  logic [USER_W-1:0] m_wuser;
  logic m_wvalid;
  logic m_wready = 1'b0;
  logic [CNT_W-1:0] wr_count, rd_count;
  logic almost_full, almost_empty;

  always #10 clk = ~clk;  // 50 MHz

  wchan_fwft_fifo #(.DATA_W(DATA_W), .USER_W(USER_W), .DEPTH(DEPTH),
                    .AFULL_TH(AFT), .AEMPTY_TH(AET)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wlast(s_wlast), .s_wuser(s_wuser),
    .s_wvalid(s_wvalid), .s_wready(s_wready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wuser(m_wuser),
    .m_wvalid(m_wvalid), .m_wready(m_wready),
    .wr_count(wr_count), .rd_count(rd_count),
    .almost_full(almost_full), .almost_empty(almost_empty)
  );

  int checks = 0;
  int errors = 0;
  logic [WORD_W-1:0] model_q[$];
  bit ready_ok = 0;
  logic [WORD_W-1:0] dropped = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] mk(input int i);
    logic [DATA_W-1:0] d = DATA_W'(32'hA500_0000 + i * 32'h0101_0003);
    logic [STRB_W-1:0] s = STRB_W'(i * 5 + 1);
    logic l = (i % 3 == 2);
    logic [USER_W-1:0] u = USER_W'(15 - (i % 16));
    return {u, l, s, d};
  endfunction

  // Compares every port against the bench model; runs at a quiet time.
  task automatic check_ports(input string ctx);
    int n = model_q.size();
    chk({ctx, " R2 ready"}, 64'(s_wready), 64'(ready_ok && n < DEPTH));
    chk({ctx, " R3 valid"}, 64'(m_wvalid), 64'(n != 0));
    chk({ctx, " R7 wr_count"}, 64'(wr_count), 64'(n));
    chk({ctx, " R7 rd_count"}, 64'(rd_count), 64'(n));
    chk({ctx, " R8 almost_empty"}, 64'(almost_empty), 64'(n <= AET));
    chk({ctx, " R9 almost_full"}, 64'(almost_full), 64'(n >= AFT));
    if (n != 0)
      chk({ctx, " R4 R6 head fields"}, 64'({m_wuser, m_wlast, m_wstrb, m_wdata}), 64'(model_q[0]));
  endtask

  // One cycle: drive at negedge, check, let the edge happen, update model.
  task automatic step(input bit push, input logic [WORD_W-1:0] w, input bit pop, input string ctx);
    bit acc_push, acc_pop;
    {s_wuser, s_wlast, s_wstrb, s_wdata} = w;
    s_wvalid = push;
    m_wready = pop;
    #2;
    check_ports(ctx);
    acc_push = push && ready_ok && model_q.size() < DEPTH;  // R1
    acc_pop  = pop && model_q.size() != 0;
    @(posedge clk);
    #1;
    if (acc_pop) void'(model_q.pop_front());
    if (acc_push) model_q.push_back(w);
    @(negedge clk);
    s_wvalid = 1'b0;
    m_wready = 1'b0;
  endtask

  task automatic do_reset_release();
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R10 ready low before first edge", 64'(s_wready), 64'(0));
    @(posedge clk);
    #1;
    ready_ok = 1;
    @(negedge clk);
    chk("R10 ready up one edge after release", 64'(s_wready), 64'(1));
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 ready in reset", 64'(s_wready), 64'(0));
    chk("R10 valid in reset", 64'(m_wvalid), 64'(0));
    chk("R10 count in reset", 64'(wr_count), 64'(0));
    chk("R8 almost_empty in reset", 64'(almost_empty), 64'(1));
    do_reset_release();
  endtask

  task automatic t_fall_through();
    step(1, mk(100), 0, "fwft push");
    #2;
    chk("R5 valid after first push", 64'(m_wvalid), 64'(1));
    chk("R5 head fields", 64'({m_wuser, m_wlast, m_wstrb, m_wdata}), 64'(mk(100)));
    step(0, '0, 1, "fwft pop");
    check_ports("fwft empty");
  endtask

  task automatic t_fill_full();
    for (int i = 0; i < DEPTH; i++) step(1, mk(i), 0, "fill");
    check_ports("full");
    chk("R7 count reads depth", 64'(wr_count), 64'(DEPTH));
    chk("R2 ready low when full", 64'(s_wready), 64'(0));
  endtask

  task automatic t_overflow();
    dropped = mk(999);
    for (int i = 0; i < 3; i++) step(1, dropped, 0, "R1 push while full");
    chk("R1 count unchanged", 64'(wr_count), 64'(DEPTH));
  endtask

  task automatic t_full_pop();
    step(1, mk(500), 1, "R11 pop at full");
    #2;
    chk("R11 count after pop", 64'(wr_count), 64'(DEPTH - 1));
    chk("R11 ready next cycle", 64'(s_wready), 64'(1));
    step(1, mk(501), 0, "R11 push after pop");
    chk("R11 refilled", 64'(wr_count), 64'(DEPTH));
  endtask

  task automatic t_drain();
    while (model_q.size() != 0) step(0, '0, 1, "drain");
    check_ports("drained");
    chk("R3 valid low when empty", 64'(m_wvalid), 64'(0));
  endtask

  task automatic t_simul();
    for (int i = 0; i < 3; i++) step(1, mk(200 + i), 0, "simul prep");
    for (int i = 0; i < 6; i++) step(1, mk(300 + i), 1, "R7 push and pop");
    chk("R7 same count after push and pop", 64'(wr_count), 64'(3));
    t_drain();
  endtask

  task automatic t_thresholds();
    for (int i = 0; i < AFT + 1; i++) step(1, mk(50 + i), 0, "R9 R8 climb");
    for (int i = 0; i < AFT + 1; i++) step(0, '0, 1, "R9 R8 descend");
    check_ports("thresholds end");
  endtask

  task automatic t_async_reset();
    for (int i = 0; i < 5; i++) step(1, mk(700 + i), 0, "pre reset");
    #5;
    rst_n = 1'b0;
    #1;
    chk("R10 async count clear", 64'(wr_count), 64'(0));
    chk("R10 async valid low", 64'(m_wvalid), 64'(0));
    chk("R10 async ready low", 64'(s_wready), 64'(0));
    model_q.delete();
    ready_ok = 0;
    @(posedge clk);
    do_reset_release();
    check_ports("after second reset");
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_fall_through();
    t_fill_full();
    t_overflow();
    t_full_pop();
    t_drain();
    t_simul();
    t_thresholds();
    t_async_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule